// File: doc/BRIEF.md
# DRAM Refresh and Address Multiplexer

This block fronts a dynamic memory array of 2^ROW_W rows by 2^COL_W columns of DATA_W-bit cells. The defaults of 2048 rows, 2048 columns and 4-bit cells give 16 Mbit. A host issues single-word reads and writes with a flat word address. The block splits that address into a row half and a column half and sends both halves over one shared address bus, one after the other. A row strobe qualifies the row phase and a column strobe qualifies the column phase.

The cells lose charge over time. An interval timer inside the block raises a refresh request at a fixed period. A row counter then picks the next row, which is opened with the row strobe alone and then closed again. Opening a row reads it out into the sense amplifiers, and closing it writes the same data back. Host accesses are held off with `ready_o` while a refresh is pending or running, and also while an access is in flight. Refresh takes precedence over a waiting host request, but an access that has already started is never cut short.

Top module: `dram_refresh_mux`

## Requirements
- R1: While reset is held and right after it, `row_stb_o`, `col_stb_o` and `dram_we_o` are low, `ready_o` is high and `rdata_o` is zero.
- R2: During a host access, the bus `addr_o` first carries the row field `addr_i[AW-1:COL_W]` with only the row strobe high. It then carries the column field `addr_i[COL_W-1:0]` with both strobes high, and the column stays stable while the column strobe is high.
- R3: The column strobe is high only while the row strobe is high, and the row strobe is always high alone for at least one cycle before the column strobe rises.
- R4: A request is accepted on a rising edge where `req_i` and `ready_o` are both high. The column strobe is then held for CAS_LAT cycles and `ready_o` returns high CAS_LAT+2 cycles after the accepting edge, provided no refresh intervenes. By then a read has placed the cell value on `rdata_o`, or a write has stored `wdata_i` through `dram_we_o`, which is high only with the column strobe.
- R5: `ready_o` is low for the whole of every access and every refresh, and it is never high while either strobe is high.
- R6: A refresh request is raised every REF_INTERVAL cycles. With no host traffic, consecutive refreshes start exactly REF_INTERVAL cycles apart.
- R7: A refresh opens one row with the row strobe alone for RAS_CYC cycles, with the column strobe and `dram_we_o` low throughout.
- R8: The refresh row counter starts at 0, advances by one after each refresh, and wraps from 2^ROW_W-1 to 0. Its value is the address driven during the refresh.
- R9: A refresh that falls due during an access starts only after that access ends. Under continuous host traffic, the gap between refresh starts stays within REF_INTERVAL plus or minus CAS_LAT+3 cycles.
- R10: Every row is refreshed at least once in each span of 2^ROW_W·REF_INTERVAL cycles, plus the same slack, so stored data survives long idle and busy periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | ROW_W+COL_W | Host word address, row field in the upper bits |
| wdata_i | input | DATA_W | Host write data |
| ready_o | output | 1 | Block idle and able to accept a request |
| rdata_o | output | DATA_W | Data from the last read |
| addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| row_stb_o | output | 1 | Row strobe, active high |
| col_stb_o | output | 1 | Column strobe, active high |
| dram_we_o | output | 1 | Array write enable |
| dram_wdata_o | output | DATA_W | Array write data |
| dram_rdata_i | input | DATA_W | Array read data |

## Verification
The bound checker enforces the strobe rules on every cycle: the column strobe only inside the row strobe, a row-only phase before any column phase, a stable column address, `ready_o` never high over an open row, a busy cycle after each acceptance, and writes only under the column strobe. The bench connects a small array model whose cells decay when a row is left unrestored too long. Only those scenarios can show the field split of each address, the refresh row sequence with its wrap, the exact refresh spacing and duration, the access latency, refresh deferral under traffic, and data that survives long idle periods.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seq_state_e;
endpackage

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int ROW_W        = 11,
  parameter int REF_INTERVAL = 1560
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_start_i,
  input  logic             ref_done_i,
  output logic             ref_pend_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam int TW = $clog2(REF_INTERVAL);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q      <= '0;
      ref_pend_o <= 1'b0;
      ref_row_o  <= '0;
    end else begin
      if (ref_start_i) ref_pend_o <= 1'b0;
      // interval expiry wins over a same-cycle clear
      if (tmr_q == TW'(REF_INTERVAL - 1)) begin
        tmr_q      <= '0;
        ref_pend_o <= 1'b1;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (ref_done_i) ref_row_o <= ref_row_o + 1'b1;  // natural wrap
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0]                 haddr_i,
  input  logic [ROW_W-1:0]                       ref_row_i,
  input  logic                                   ref_sel_i,
  input  logic                                   col_sel_i,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] addr_o
);
  localparam int BW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int AW = ROW_W + COL_W;

  logic [BW-1:0] row_f, col_f, ref_f;

  always_comb begin
    row_f = BW'(haddr_i[AW-1:COL_W]);
    col_f = BW'(haddr_i[COL_W-1:0]);
    ref_f = BW'(ref_row_i);
    if (ref_sel_i)      addr_o = ref_f;
    else if (col_sel_i) addr_o = col_f;
    else                addr_o = row_f;
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctl_pkg::*;
#(
  parameter int AW      = 22,
  parameter int DATA_W  = 4,
  parameter int CAS_LAT = 2,
  parameter int RAS_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ref_pend_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [AW-1:0]     haddr_o,
  output logic              ref_start_o,
  output logic              ref_done_o,
  output logic              ref_sel_o,
  output logic              col_sel_o,
  output logic              row_stb_o,
  output logic              col_stb_o,
  output logic              dram_we_o,
  output logic [DATA_W-1:0] dram_wdata_o
);
  localparam int MAXC = (CAS_LAT > RAS_CYC) ? CAS_LAT : RAS_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cas_last, ras_last;

  assign cas_last = (cnt_q == CW'(CAS_LAT - 1));
  assign ras_last = (cnt_q == CW'(RAS_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      haddr_o <= '0;
      rdata_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (ref_pend_i) begin
            st_q <= ST_REF;  // refresh ahead of a waiting host
          end else if (req_i) begin
            st_q    <= ST_ROW;
            we_q    <= we_i;
            wdata_q <= wdata_i;
            haddr_o <= addr_i;
          end
        end
        ST_ROW: st_q <= ST_COL;
        ST_COL: begin
          if (cas_last) begin
            st_q  <= ST_PRE;
            cnt_q <= '0;
            if (!we_q) rdata_o <= dram_rdata_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REF: begin
          if (ras_last) begin
            st_q  <= ST_PRE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PRE:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (st_q == ST_IDLE) && !ref_pend_i;
  assign ref_start_o  = (st_q == ST_IDLE) && ref_pend_i;
  assign ref_done_o   = (st_q == ST_REF) && ras_last;
  assign ref_sel_o    = (st_q == ST_REF);
  assign col_sel_o    = (st_q == ST_COL);
  assign row_stb_o    = (st_q == ST_ROW) || (st_q == ST_COL) || (st_q == ST_REF);
  assign col_stb_o    = (st_q == ST_COL);
  assign dram_we_o    = (st_q == ST_COL) && we_q;
  assign dram_wdata_o = wdata_q;
endmodule

// File: rtl/dram_refresh_mux.sv
module dram_refresh_mux #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 1560,
  parameter int CAS_LAT      = 2,
  parameter int RAS_CYC      = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_i,
  input  logic                                   we_i,
  input  logic [ROW_W+COL_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                      wdata_i,
  output logic                                   ready_o,
  output logic [DATA_W-1:0]                      rdata_o,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] addr_o,
  output logic                                   row_stb_o,
  output logic                                   col_stb_o,
  output logic                                   dram_we_o,
  output logic [DATA_W-1:0]                      dram_wdata_o,
  input  logic [DATA_W-1:0]                      dram_rdata_i
);
  localparam int AW = ROW_W + COL_W;

  logic             ref_pend, ref_start, ref_done, ref_sel, col_sel;
  logic [ROW_W-1:0] ref_row;
  logic [AW-1:0]    haddr;

  dram_ref_sched #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_start_i(ref_start),
    .ref_done_i (ref_done),
    .ref_pend_o (ref_pend),
    .ref_row_o  (ref_row)
  );

  dram_seq_fsm #(
    .AW(AW), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .RAS_CYC(RAS_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ref_pend_i  (ref_pend),
    .dram_rdata_i(dram_rdata_i),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .haddr_o     (haddr),
    .ref_start_o (ref_start),
    .ref_done_o  (ref_done),
    .ref_sel_o   (ref_sel),
    .col_sel_o   (col_sel),
    .row_stb_o   (row_stb_o),
    .col_stb_o   (col_stb_o),
    .dram_we_o   (dram_we_o),
    .dram_wdata_o(dram_wdata_o)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
    .haddr_i  (haddr),
    .ref_row_i(ref_row),
    .ref_sel_i(ref_sel),
    .col_sel_i(col_sel),
    .addr_o   (addr_o)
  );
endmodule

// File: rtl/dram_refresh_mux_chk.sv
module dram_refresh_mux_chk #(
  parameter int BW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          row_stb_o,
  input logic          col_stb_o,
  input logic          dram_we_o,
  input logic [BW-1:0] addr_o
);
  // R3
  col_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_stb_o |-> row_stb_o);

  // R3
  row_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_stb_o) |-> $past(row_stb_o));

  // R2
  col_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_o && $past(col_stb_o)) |-> $stable(addr_o));

  // R5
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!row_stb_o && !col_stb_o));

  // R5
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  // R4
  we_in_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> col_stb_o);
endmodule

bind dram_refresh_mux dram_refresh_mux_chk #(.BW($bits(addr_o))) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .ready_o  (ready_o),
  .row_stb_o(row_stb_o),
  .col_stb_o(col_stb_o),
  .dram_we_o(dram_we_o),
  .addr_o   (addr_o)
);

// File: tb/dram_refresh_mux_tb.sv
`timescale 1ns/1ps
module dram_refresh_mux_tb;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 4;
  localparam int REF_INTERVAL = 40, CAS_LAT = 2, RAS_CYC = 3;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;
  localparam int AW = ROW_W + COL_W, BW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int SL = CAS_LAT + 3;
  localparam int LIMIT = ROWS * REF_INTERVAL + 2 * SL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic ready_o, row_stb, col_stb, dram_we;
  logic [DATA_W-1:0] rdata_o, dram_wdata, dram_rdata;
  logic [BW-1:0] addr_o;

  always #2.5 clk = ~clk;

  dram_refresh_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .REF_INTERVAL(REF_INTERVAL), .CAS_LAT(CAS_LAT), .RAS_CYC(RAS_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o), .addr_o(addr_o),
    .row_stb_o(row_stb), .col_stb_o(col_stb), .dram_we_o(dram_we),
    .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_rdata));

  int tests = 0, fails = 0, cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // array model with decay
  logic [DATA_W-1:0] mem [ROWS*COLS];
  int last_restore [ROWS];
  int last_ref [ROWS];
  int open_row = 0, act_t = 0, exp_row = 0, ref_count = 0, last_start = 0;
  bit act_host = 0, host_open = 0, have_last = 0, quiet = 0, prev_row = 0;
  int cur_addr = 0;

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) mem[i] = '0;
    for (int i = 0; i < ROWS; i++) begin last_restore[i] = 0; last_ref[i] = -1; end
  end

  always_comb begin
    dram_rdata = '0;
    if (col_stb)
      dram_rdata = mem[open_row*COLS + int'(addr_o)] ^
                   (((cycle - last_restore[open_row]) > LIMIT) ? {DATA_W{1'b1}} : '0);
  end

  always @(negedge clk) if (rst_n) begin
    if (row_stb && !prev_row) begin
      open_row = int'(addr_o); act_t = cycle; act_host = host_open; host_open = 0;
      if (act_host) begin
        chk(int'(addr_o) == (cur_addr >> COL_W), "R2 row field", int'(addr_o), cur_addr >> COL_W);
      end else begin
        chk(int'(addr_o) == exp_row, "R8 refresh row", int'(addr_o), exp_row);
        if (have_last) begin
          if (quiet) chk(cycle - last_start == REF_INTERVAL, "R6 idle spacing",
                         cycle - last_start, REF_INTERVAL);
          else chk((cycle - last_start >= REF_INTERVAL - SL) && (cycle - last_start <= REF_INTERVAL + SL),
                   "R9 busy spacing", cycle - last_start, REF_INTERVAL);
        end
        have_last = 1; last_start = cycle;
        if (last_ref[open_row] >= 0)
          chk(cycle - last_ref[open_row] <= ROWS*REF_INTERVAL + SL, "R10 row period",
              cycle - last_ref[open_row], ROWS*REF_INTERVAL);
        last_ref[open_row] = cycle;
      end
    end
    if (row_stb && !act_host) begin
      chk(!col_stb && !dram_we, "R7 refresh strobes", int'(col_stb), 0);
      chk(!ready_o, "R5 ready in refresh", int'(ready_o), 0);
    end
    if (col_stb && act_host)
      chk(int'(addr_o) == (cur_addr % COLS), "R2 col field", int'(addr_o), cur_addr % COLS);
    if (col_stb && dram_we) mem[open_row*COLS + int'(addr_o)] = dram_wdata;
    if (!row_stb && prev_row) begin
      last_restore[open_row] = cycle;
      if (!act_host) begin
        chk(cycle - act_t == RAS_CYC, "R7 refresh length", cycle - act_t, RAS_CYC);
        exp_row = (exp_row + 1) % ROWS;  // R8 wrap
        ref_count++;
      end
    end
    prev_row = row_stb;
  end

  function automatic int pat(input int a, input int s);
    return (a * 7 + 5 + s) & ((1 << DATA_W) - 1);
  endfunction

  task automatic access(input bit w, input int a, input int d, output int rd, output int lat);
    int c0, r0;
    while (!ready_o) @(negedge clk);
    host_open = 1; cur_addr = a;
    req = 1; we = w; addr = AW'(a); wdata = DATA_W'(d);
    c0 = cycle; r0 = ref_count;
    @(negedge clk);
    req = 0; we = 0;
    while (!ready_o) @(negedge clk);
    lat = (ref_count == r0) ? (cycle - c0) : -1;
    rd = int'(rdata_o);
  endtask

  int rd, lat, nlat;

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(ready_o && !row_stb && !col_stb && !dram_we && rdata_o == 0, "R1 reset state",
        int'(ready_o), 1);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o && !row_stb, "R1 after release", int'(ready_o), 1);
    nlat = 0;
    // R4 write sweep
    for (int a = 0; a < ROWS*COLS; a++) begin
      access(1, a, pat(a, 0), rd, lat);
      if (lat >= 0) begin
        chk(lat == CAS_LAT + 3, "R4 write latency", lat, CAS_LAT + 3); nlat++;
      end
    end
    // R4 read sweep, reverse order
    for (int a = ROWS*COLS - 1; a >= 0; a--) begin
      access(0, a, 0, rd, lat);
      chk(rd == pat(a, 0), "R4 read data", rd, pat(a, 0));
      if (lat >= 0) chk(lat == CAS_LAT + 3, "R4 read latency", lat, CAS_LAT + 3);
    end
    chk(nlat > 0, "R4 latency samples", nlat, 1);
    // R6 idle spacing, R10 retention over long idle
    repeat (2 * REF_INTERVAL) @(negedge clk);
    quiet = 1;
    repeat (3 * ROWS * REF_INTERVAL) @(negedge clk);
    quiet = 0;
    have_last = 0;
    for (int a = 0; a < ROWS*COLS; a++) begin
      access(0, a, 0, rd, lat);
      chk(rd == pat(a, 0), "R10 data after idle", rd, pat(a, 0));
    end
    // R9 back-to-back traffic with overwrite
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < ROWS*COLS; a++) access(1, a, pat(a, k + 1), rd, lat);
    for (int a = 0; a < ROWS*COLS; a++) begin
      access(0, a, 0, rd, lat);
      chk(rd == pat(a, 4), "R9 data under traffic", rd, pat(a, 4));
    end
    // R8 wrap seen, R10 every row refreshed
    chk(ref_count > 2 * ROWS, "R8 wrap count", ref_count, 2 * ROWS);
    for (int r = 0; r < ROWS; r++) chk(last_ref[r] >= 0, "R10 row visited", last_ref[r], 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule